// File: doc/BRIEF.md
# RGB Panel Timing Generator

This block drives a parallel 24-bit RGB TFT panel at pixel-clock rate. A horizontal counter and a vertical counter walk through every position of the frame. From their state the block produces the active-low line and frame sync pulses and the active-high data-enable. It also issues a pixel-request strobe, together with the x/y coordinates of the requested pixel, toward a frame-buffer reader that sits outside the block. The reader returns a 24-bit word, and the block places that word on the red, green and blue output lanes while data-enable is high.

The default geometry is a 1024 x 600 active area. Each line has a 20-clock sync pulse, a 160-clock back porch and a 140-clock front porch, for 1344 clocks per line. Each frame has a 3-line sync pulse, a 20-line back porch and a 12-line front porch, for 635 lines per frame. All of these values are module parameters. A run-time input chooses between sync signalling and DE-only signalling. A second input exchanges the red and blue lanes, so that a buffer stored in blue-first order is shown correctly. A third input picks one of two frame buffers. The block adopts that choice only as the frame's active area ends, so a frame is never shown half from one buffer and half from the other.

Top module: `lcdt_timing_gen`

## Requirements
- R1: While `rst_i` is high at a clock edge, both counters go to zero and the outputs become inactive: `hs_n_o`=1, `vs_n_o`=1, `de_o`=0, `req_o`=0, `x_o`=0, `y_o`=0, `rgb_o`=0 and `buf_sel_o`=0.
- R2: A line lasts H_SYNC+H_BACK+H_ACTIVE+H_FRONT clocks, in the order sync, back porch, active, front porch. On every active line `req_o` is high for exactly H_ACTIVE consecutive clocks. Counter position p becomes visible on `req_o` in the cycle after the counter holds p, and position 0 is the first clock after reset is released.
- R3: A frame lasts V_SYNC+V_BACK+V_ACTIVE+V_FRONT lines, in the order sync, back porch, active, front porch. `req_o` is never high on a non-active line, and each frame carries exactly H_ACTIVE*V_ACTIVE requests.
- R4: While `req_o` is high, `x_o` is the column of the requested pixel (0 at the first active clock, +1 per clock) and `y_o` is the active line index (0 for the first active line). Both are 0 while `req_o` is low.
- R5: `de_o` repeats `req_o` exactly REQ_LEAD clocks later (default 1).
- R6: With `mode_de_i`=0, `hs_n_o` is low for the first H_SYNC clocks of every line and `vs_n_o` is low for the first V_SYNC lines of every frame. Both are aligned with `de_o`, so `vs_n_o` falls in the same clock as `hs_n_o`.
- R7: With `mode_de_i`=1, `hs_n_o` and `vs_n_o` stay at 1 from the clock after the mode is sampled high. `de_o` still marks the valid pixels.
- R8: With `swap_rb_i`=0 and `de_o`=1, `rgb_o` equals `pix_i`. Red is on bits 7:0, green on bits 15:8 and blue on bits 23:16. A reader that registers its word on the clock after `req_o` lines up with `de_o` when REQ_LEAD is 1.
- R9: With `swap_rb_i`=1 and `de_o`=1, `rgb_o[7:0]`=`pix_i[23:16]`, `rgb_o[23:16]`=`pix_i[7:0]` and green is unchanged. The swap acts in the same cycle.
- R10: While `de_o`=0, `rgb_o` is 0.
- R11: `buf_sel_o` takes the value of `bank_req_i` sampled on the last clock of the last active line. It changes at no other time, so the new value shows from the first clock of the first front-porch line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_i | input | 1 | Synchronous reset, active high |
| mode_de_i | input | 1 | 1 = DE-only signalling, 0 = sync signalling |
| swap_rb_i | input | 1 | Exchange red and blue lanes |
| bank_req_i | input | 1 | Requested frame-buffer bank |
| pix_i | input | 24 | Pixel word from the reader, red 7:0, green 15:8, blue 23:16 |
| req_o | output | 1 | Pixel request strobe toward the reader |
| x_o | output | clog2(H_ACTIVE) | Column of the requested pixel |
| y_o | output | clog2(V_ACTIVE) | Line of the requested pixel |
| de_o | output | 1 | Data enable, active high |
| hs_n_o | output | 1 | Line sync, active low |
| vs_n_o | output | 1 | Frame sync, active low |
| rgb_o | output | 24 | Panel data lanes |
| buf_sel_o | output | 1 | Bank currently scanned |

## Verification
The scan is tested with a shrunken geometry, first in sync signalling, where sync pulse widths, porch placement and request counts per line and per frame are compared cycle by cycle with a position model. The same scan then runs in DE-only mode. That run separates sync pulses that are merely masked from sync pulses that are missing altogether, because data-enable has to stay identical in both modes. The pixel pattern encodes column, line and bank in different lanes, so a shifted pixel, a lane that is not exchanged, or a frame taken from the wrong bank each shows up as a distinct mismatch. The bank request is toggled several times inside a frame and once just after the boundary, and a reset is applied mid-frame, to show that only the boundary sample is adopted and that the scan restarts from position zero.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;

    localparam int unsigned LANE_W = 8;
    localparam int unsigned PIX_W  = 3 * LANE_W;

    // Lane layout of a pixel word: blue high, red low.
    typedef struct packed {
        logic [LANE_W-1:0] blu;
        logic [LANE_W-1:0] grn;
        logic [LANE_W-1:0] red;
    } lcdt_rgb_t;

    // Per-position control decoded from the counters.
    typedef struct packed {
        logic hsync;
        logic vsync;
        logic active;
    } lcdt_ctl_t;

    localparam lcdt_ctl_t CTL_IDLE = '{hsync: 1'b0, vsync: 1'b0, active: 1'b0};

    function automatic lcdt_rgb_t lcdt_swap_rb(lcdt_rgb_t p);
        return '{blu: p.red, grn: p.grn, red: p.blu};
    endfunction

    function automatic int unsigned lcdt_cw(int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/lcdt_axis_cnt.sv
module lcdt_axis_cnt #(
    parameter int unsigned TOTAL = 1344,
    parameter int unsigned CW    = 11
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          step_i,
    output logic [CW-1:0] cnt_o
);
    localparam logic [CW-1:0] LAST = CW'(TOTAL - 1);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_o <= '0;
        end else if (step_i) begin
            cnt_o <= (cnt_o == LAST) ? '0 : cnt_o + 1'b1;
        end
    end

endmodule

// File: rtl/lcdt_ctl_pipe.sv
module lcdt_ctl_pipe
    import lcdt_pkg::*;
#(
    parameter int DEPTH = 1
) (
    input  logic      clk_i,
    input  logic      rst_i,
    input  lcdt_ctl_t ctl_i,
    output lcdt_ctl_t ctl_o
);
    generate
        if (DEPTH == 0) begin : g_wire
            assign ctl_o = ctl_i;
        end else begin : g_regs
            lcdt_ctl_t stg_q [DEPTH];

            always_ff @(posedge clk_i) begin
                if (rst_i) begin
                    for (int i = 0; i < DEPTH; i++) stg_q[i] <= CTL_IDLE;
                end else begin
                    stg_q[0] <= ctl_i;
                    for (int i = 1; i < DEPTH; i++) stg_q[i] <= stg_q[i-1];
                end
            end

            assign ctl_o = stg_q[DEPTH-1];
        end
    endgenerate

endmodule

// File: rtl/lcdt_lane_map.sv
module lcdt_lane_map
    import lcdt_pkg::*;
(
    input  logic [PIX_W-1:0] pix_i,
    input  logic             swap_i,
    input  logic             en_i,
    output logic [PIX_W-1:0] rgb_o
);
    lcdt_rgb_t word;

    always_comb begin
        word = lcdt_rgb_t'(pix_i);
        if (swap_i) word = lcdt_swap_rb(word);
        rgb_o = en_i ? PIX_W'(word) : '0;
    end

endmodule

// File: rtl/lcdt_bank_latch.sv
module lcdt_bank_latch (
    input  logic clk_i,
    input  logic rst_i,
    input  logic take_i,
    input  logic req_i,
    output logic sel_o
);
    always_ff @(posedge clk_i) begin
        if (rst_i)       sel_o <= 1'b0;
        else if (take_i) sel_o <= req_i;
    end

endmodule

// File: rtl/lcdt_timing_gen.sv
module lcdt_timing_gen
    import lcdt_pkg::*;
#(
    parameter int unsigned H_ACTIVE = 1024,
    parameter int unsigned H_SYNC   = 20,
    parameter int unsigned H_BACK   = 160,
    parameter int unsigned H_FRONT  = 140,
    parameter int unsigned V_ACTIVE = 600,
    parameter int unsigned V_SYNC   = 3,
    parameter int unsigned V_BACK   = 20,
    parameter int unsigned V_FRONT  = 12,
    parameter int          REQ_LEAD = 1,
    localparam int unsigned XW = lcdt_cw(H_ACTIVE),
    localparam int unsigned YW = lcdt_cw(V_ACTIVE)
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             mode_de_i,
    input  logic             swap_rb_i,
    input  logic             bank_req_i,
    input  logic [PIX_W-1:0] pix_i,
    output logic             req_o,
    output logic [XW-1:0]    x_o,
    output logic [YW-1:0]    y_o,
    output logic             de_o,
    output logic             hs_n_o,
    output logic             vs_n_o,
    output logic [PIX_W-1:0] rgb_o,
    output logic             buf_sel_o
);
    localparam int unsigned H_TOTAL = H_SYNC + H_BACK + H_ACTIVE + H_FRONT;
    localparam int unsigned V_TOTAL = V_SYNC + V_BACK + V_ACTIVE + V_FRONT;
    localparam int unsigned HCW     = lcdt_cw(H_TOTAL);
    localparam int unsigned VCW     = lcdt_cw(V_TOTAL);

    localparam logic [HCW-1:0] H_SYNC_END = HCW'(H_SYNC);
    localparam logic [HCW-1:0] H_ACT_BEG  = HCW'(H_SYNC + H_BACK);
    localparam logic [HCW-1:0] H_ACT_END  = HCW'(H_SYNC + H_BACK + H_ACTIVE);
    localparam logic [HCW-1:0] H_LAST     = HCW'(H_TOTAL - 1);
    localparam logic [VCW-1:0] V_SYNC_END = VCW'(V_SYNC);
    localparam logic [VCW-1:0] V_ACT_BEG  = VCW'(V_SYNC + V_BACK);
    localparam logic [VCW-1:0] V_ACT_END  = VCW'(V_SYNC + V_BACK + V_ACTIVE);
    localparam logic [VCW-1:0] V_ACT_LAST = VCW'(V_SYNC + V_BACK + V_ACTIVE - 1);
    localparam logic [VCW-1:0] V_FP_FIRST = VCW'(V_SYNC + V_BACK + V_ACTIVE);

    // ---------------- position counters ----------------
    logic [HCW-1:0] hcnt;
    logic [VCW-1:0] vcnt;
    logic           h_last;

    assign h_last = (hcnt == H_LAST);

    lcdt_axis_cnt #(.TOTAL(H_TOTAL), .CW(HCW)) u_hcnt (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .step_i(1'b1),
        .cnt_o (hcnt)
    );

    lcdt_axis_cnt #(.TOTAL(V_TOTAL), .CW(VCW)) u_vcnt (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .step_i(h_last),
        .cnt_o (vcnt)
    );

    // ---------------- region decode, request stage ----------------
    lcdt_ctl_t ctl_next, ctl_req_q, ctl_out;
    logic      h_in, v_in;

    always_comb begin
        h_in            = (hcnt >= H_ACT_BEG) && (hcnt < H_ACT_END);
        v_in            = (vcnt >= V_ACT_BEG) && (vcnt < V_ACT_END);
        ctl_next.hsync  = (hcnt < H_SYNC_END);
        ctl_next.vsync  = (vcnt < V_SYNC_END);
        ctl_next.active = h_in && v_in;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ctl_req_q <= CTL_IDLE;
            x_o       <= '0;
            y_o       <= '0;
        end else begin
            ctl_req_q <= ctl_next;
            x_o       <= ctl_next.active ? XW'(hcnt - H_ACT_BEG) : '0;
            y_o       <= ctl_next.active ? YW'(vcnt - V_ACT_BEG) : '0;
        end
    end

    assign req_o = ctl_req_q.active;

    // ---------------- panel stage, REQ_LEAD clocks later ----------------
    lcdt_ctl_pipe #(.DEPTH(REQ_LEAD)) u_pipe (
        .clk_i(clk_i),
        .rst_i(rst_i),
        .ctl_i(ctl_req_q),
        .ctl_o(ctl_out)
    );

    logic mode_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) mode_q <= 1'b0;
        else       mode_q <= mode_de_i;
    end

    assign de_o   = ctl_out.active;
    assign hs_n_o = ~(ctl_out.hsync & ~mode_q);
    assign vs_n_o = ~(ctl_out.vsync & ~mode_q);

    lcdt_lane_map u_lanes (
        .pix_i (pix_i),
        .swap_i(swap_rb_i),
        .en_i  (ctl_out.active),
        .rgb_o (rgb_o)
    );

    // ---------------- bank select, adopted as active area ends ----------------
    lcdt_bank_latch u_bank (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .take_i(h_last && (vcnt == V_ACT_LAST)),
        .req_i (bank_req_i),
        .sel_o (buf_sel_o)
    );

    // ---------------- assertions ----------------
    p_bank_boundary_r11: assert property (@(posedge clk_i) disable iff (rst_i)
        (buf_sel_o != $past(buf_sel_o)) |-> (hcnt == '0 && vcnt == V_FP_FIRST));

    p_de_quiet_sync_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && $past(mode_de_i)) |-> (hs_n_o && vs_n_o));

    p_x_step_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (req_o && $past(req_o)) |-> (x_o == XW'($past(x_o) + 1'b1)));

    p_y_range_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        req_o |-> (32'(y_o) < V_ACTIVE));

    p_frame_on_line_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        ($fell(vs_n_o) && !$past(mode_de_i) && !$past(mode_de_i, 2)) |-> !hs_n_o);

    generate
        if (REQ_LEAD == 1) begin : g_lead_chk
            p_req_to_de_r5: assert property (@(posedge clk_i) disable iff (rst_i)
                req_o |=> de_o);
            p_de_from_req_r5: assert property (@(posedge clk_i) disable iff (rst_i)
                de_o |-> $past(req_o));
        end
    endgenerate

endmodule

// File: tb/lcdt_timing_gen_test.sv
module lcdt_timing_gen_test;

    localparam int HA = 8, HS = 2, HB = 3, HF = 4;
    localparam int VA = 4, VS = 1, VB = 2, VF = 2;
    localparam int HT = HS + HB + HA + HF;
    localparam int VT = VS + VB + VA + VF;
    localparam int FT = HT * VT;
    localparam int LEAD = 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode_de = 1'b0;
    logic        swap_rb = 1'b0;
    logic        bank_req = 1'b0;
    logic [23:0] pix;
    logic        req_o, de_o, hs_n_o, vs_n_o, buf_sel_o;
    logic [2:0]  x_o;
    logic [1:0]  y_o;
    logic [23:0] rgb_o;

    int n_checks = 0;
    int n_errors = 0;

    always #5 clk = ~clk;

    lcdt_timing_gen #(
        .H_ACTIVE(HA), .H_SYNC(HS), .H_BACK(HB), .H_FRONT(HF),
        .V_ACTIVE(VA), .V_SYNC(VS), .V_BACK(VB), .V_FRONT(VF),
        .REQ_LEAD(LEAD)
    ) uut (
        .clk_i(clk), .rst_i(rst), .mode_de_i(mode_de), .swap_rb_i(swap_rb),
        .bank_req_i(bank_req), .pix_i(pix), .req_o(req_o), .x_o(x_o), .y_o(y_o),
        .de_o(de_o), .hs_n_o(hs_n_o), .vs_n_o(vs_n_o), .rgb_o(rgb_o),
        .buf_sel_o(buf_sel_o)
    );

    function automatic logic [23:0] pat(int x, int y, bit b);
        return {8'(y * 37 + (b ? 128 : 0)), 8'(x * 5 + 1), 8'(x + y * 16 + 3)};
    endfunction

    function automatic logic [23:0] sw(logic [23:0] p);
        return {p[7:0], p[15:8], p[23:16]};
    endfunction

    function automatic bit in_act(int h, int v);
        return h >= HS + HB && h < HS + HB + HA && v >= VS + VB && v < VS + VB + VA;
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s actual %0h expected %0h at %0t", rq, what, act, exp, $time);
        end
    endtask

    // Frame-buffer reader: registers the word on the clock after a request.
    logic [23:0] rd_q = '0;
    always @(posedge clk) if (req_o) rd_q <= pat(int'(x_o), int'(y_o), buf_sel_o);
    assign pix = rd_q;

    // Scoreboard: model pushes expected words, monitor pops them on DE.
    logic [23:0] exp_q[$];
    int  k = 0, line_req = 0, frame_req = 0;
    bit  exp_bank = 1'b0;

    always @(negedge clk) begin
        if (rst) begin
            k = 0; line_req = 0; frame_req = 0; exp_bank = 1'b0;
            exp_q.delete();
        end else begin
            int n, d, hp, vp, dh, dv;
            bit am, dm, hsm, vsm;
            logic [23:0] e;
            k++;
            n  = k - 1;
            hp = n % HT;
            vp = (n / HT) % VT;
            am = in_act(hp, vp);
            // request timing: R2 inside active lines, R3 on blank lines
            if (vp >= VS + VB && vp < VS + VB + VA)
                chk(req_o == am, "R2", "req_o", req_o, am);
            else
                chk(req_o == am, "R3", "req_o blank line", req_o, am);
            if (am) begin
                chk(x_o == 3'(hp - HS - HB), "R4", "x_o", x_o, hp - HS - HB);
                chk(y_o == 2'(vp - VS - VB), "R4", "y_o", y_o, vp - VS - VB);
            end else begin
                chk(x_o == 0 && y_o == 0, "R4", "x_o/y_o idle", {x_o, y_o}, 0);
            end
            if (req_o) begin line_req++; frame_req++; end
            if (hp == HT - 1) begin
                if (vp >= VS + VB && vp < VS + VB + VA)
                    chk(line_req == HA, "R2", "requests per line", line_req, HA);
                line_req = 0;
            end
            if (hp == HT - 1 && vp == VT - 1) begin
                chk(frame_req == HA * VA, "R3", "requests per frame", frame_req, HA * VA);
                frame_req = 0;
            end
            // panel stage, LEAD clocks behind
            d  = n - LEAD;
            dh = (d >= 0) ? d % HT : 0;
            dv = (d >= 0) ? (d / HT) % VT : 0;
            dm = (d >= 0) && in_act(dh, dv);
            chk(de_o == dm, "R5", "de_o", de_o, dm);
            hsm = !((d >= 0) && dh < HS);
            vsm = !((d >= 0) && dv < VS);
            if (mode_de) begin
                chk(hs_n_o && vs_n_o, "R7", "syncs idle in DE mode", {hs_n_o, vs_n_o}, 2'b11);
            end else begin
                chk(hs_n_o == hsm, "R6", "hs_n_o", hs_n_o, hsm);
                chk(vs_n_o == vsm, "R6", "vs_n_o", vs_n_o, vsm);
            end
            if (de_o) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R8", "pixel without expected item", rgb_o, 0);
                end else begin
                    e = exp_q.pop_front();
                    if (swap_rb) chk(rgb_o == sw(e), "R9", "rgb_o swapped", rgb_o, sw(e));
                    else         chk(rgb_o == e, "R8", "rgb_o", rgb_o, e);
                end
            end else begin
                chk(rgb_o == 24'h0, "R10", "rgb_o blank", rgb_o, 0);
            end
            if (hp == HT - 1 && vp == VS + VB + VA - 1) exp_bank = bank_req;
            chk(buf_sel_o == exp_bank, "R11", "buf_sel_o", buf_sel_o, exp_bank);
            if (am) exp_q.push_back(pat(hp - HS - HB, vp - VS - VB, exp_bank));
        end
    end

    task automatic run(input int c);
        repeat (c) @(negedge clk);
    endtask

    task automatic drive(input logic m, input logic s, input logic b);
        @(negedge clk);
        #1;
        mode_de = m; swap_rb = s; bank_req = b;
    endtask

    task automatic check_reset();
        chk(hs_n_o == 1'b1, "R1", "hs_n_o in reset", hs_n_o, 1);
        chk(vs_n_o == 1'b1, "R1", "vs_n_o in reset", vs_n_o, 1);
        chk(de_o == 1'b0, "R1", "de_o in reset", de_o, 0);
        chk(req_o == 1'b0, "R1", "req_o in reset", req_o, 0);
        chk(x_o == 0 && y_o == 0, "R1", "coords in reset", {x_o, y_o}, 0);
        chk(rgb_o == 24'h0, "R1", "rgb_o in reset", rgb_o, 0);
        chk(buf_sel_o == 1'b0, "R1", "buf_sel_o in reset", buf_sel_o, 0);
    endtask

    initial begin
        #(10 * 20000);
        chk(1'b0, "WD", "watchdog expired", 0, 1);
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        run(3);
        check_reset();
        @(negedge clk); #1 rst = 1'b0;
        run(2 * FT);                       // sync mode, plain lanes, bank 0
        drive(1'b0, 1'b0, 1'b1);           // bank request toggled inside a frame
        run(20);
        drive(1'b0, 1'b0, 1'b0);
        run(10);
        drive(1'b0, 1'b0, 1'b1);
        run(FT);                           // bank 1 adopted at the boundary
        drive(1'b0, 1'b1, 1'b1);           // swap on mid-scan
        run(FT);
        drive(1'b0, 1'b1, 1'b0);
        run(FT + 20);
        drive(1'b1, 1'b0, 1'b0);           // DE-only mode
        run(2 * FT);
        drive(1'b0, 1'b0, 1'b1);           // back to sync mode
        run(FT + 60);
        @(negedge clk); #1 rst = 1'b1;     // mid-frame reset
        @(negedge clk);
        check_reset();
        run(2);
        @(negedge clk); #1 rst = 1'b0;
        run(FT + 10);
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule